// File: doc/BRIEF.md
# Timed Serial Load Sequencer

This block sits on the host side of a chain of cascaded eight-bit serial-in, latched power drivers. It takes one parallel word that covers every device in the chain through a valid/ready handshake. It then shifts the word out on a serial data line with its own shift clock and pulses a strobe so that all the driver latches update together. Every interval on the serial pins has a floor given in nanoseconds: data setup, data hold, clock high width, data valid width, the gap from the last clock to the strobe, and the strobe width. Each floor becomes a whole number of system clock cycles when the design is built. An optional blanking line can hold the driver outputs off while new bits move through the chain.

The controller is a single state machine. From `ST_IDLE`, an accepted word moves it to `ST_SETUP`. `ST_SETUP` moves to `ST_CLK_HIGH`, which moves to `ST_HOLD`. `ST_HOLD` returns to `ST_SETUP` while bits remain, and moves to `ST_STROBE_WAIT` after the last bit. `ST_STROBE_WAIT` moves to `ST_STROBE`, which moves to `ST_DONE`, and `ST_DONE` returns to `ST_IDLE` after one cycle. Each timed state lasts a fixed number of cycles, counted by a down-counter that is reloaded on every transition.

Top module: `serial_load_seq`

## Requirements
- R1: While reset is held and just after it, `in_ready` is 1 and `ser_data`, `ser_clk`, `ser_strobe` and `out_blank` are 0.
- R2: A word is taken on a rising clock edge when `in_valid` and `in_ready` are both 1. `in_ready` is then 0 for exactly W*(SETUP_LEN+CLKH_CYC+HOLD_CYC)+GAP_CYC+STB_CYC+1 cycles, where W = 8*NUM_DEV. While `in_ready` is 1, `ser_clk`, `ser_strobe` and `out_blank` are 0.
- R3: Each load makes exactly W rising edges on `ser_clk`. Bit W-1 of `in_word` is sent first and bit 0 last. After the strobe, the latch of device d (counted from the host, starting at 0) at output j holds `in_word[8*d+j]`.
- R4: `ser_data` is stable for at least SETUP_CYC cycles before each rising edge of `ser_clk`. The setup phase lasts SETUP_LEN = max(SETUP_CYC, DATA_CYC-CLKH_CYC-HOLD_CYC, CLKH_CYC-HOLD_CYC) cycles.
- R5: `ser_clk` stays high for exactly CLKH_CYC cycles per pulse.
- R6: `ser_data` does not change while `ser_clk` is high, nor for HOLD_CYC cycles after `ser_clk` falls.
- R7: Each value on `ser_data` is held for at least DATA_CYC cycles.
- R8: The strobe rises at least GAP_CYC cycles after the last rising edge of `ser_clk`, and `ser_clk` is low whenever the strobe is high.
- R9: Each load gives one strobe pulse, exactly STB_CYC cycles wide, after all W clock pulses.
- R10: If `in_blank` is 1 when the word is taken, `out_blank` is 1 from the cycle after acceptance until the strobe falls, and 0 afterwards. If `in_blank` is 0, `out_blank` stays 0.
- R11: `in_valid`, `in_word` and `in_blank` have no effect while `in_ready` is 0. The bits shifted out, the blanking and the final latched word all follow the word that was accepted.
- R12: Each interval in cycles is ceil(ns / SYS_PERIOD_NS), and never less than 1. The defaults give SETUP 8, HOLD 8, CLKH 15, DATA 15, GAP 30 and STB 10 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | Idle and able to take a word |
| in_word | input | 8*NUM_DEV | Bits for the whole chain; bit 8*d+j drives output j of device d |
| in_blank | input | 1 | Hold the driver outputs off during this load |
| ser_data | output | 1 | Serial data into the nearest device |
| ser_clk | output | 1 | Shift clock; the devices sample on its rising edge |
| ser_strobe | output | 1 | Latch-update pulse, active high |
| out_blank | output | 1 | Driver-disable line; high turns the outputs off |

## Verification
The checker assumes that reset is applied at the start. It also assumes that `in_valid` is only sampled while `in_ready` is high, so that a word offered during a load cannot start another one. Its width counters saturate at 16 bits, which assumes every timed interval fits well inside that range.

The stimulus changes inputs only at falling clock edges and holds `in_valid` until the word is taken. It then deliberately keeps offering an inverted word and an inverted blank request for a few busy cycles. The words are random from a fixed seed, plus directed patterns: all zeros, all ones, alternating bits, and single set bits at each end of the word. A behavioural model of the driver chain holds the resulting latch contents, which are compared with the word that was accepted.

// File: rtl/slsq_pkg.sv
package slsq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CLK_HIGH,
        ST_HOLD,
        ST_STROBE_WAIT,
        ST_STROBE,
        ST_DONE
    } seq_state_e;

    // whole cycles covering a nanosecond floor, never fewer than one
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/slsq_timer.sv
module slsq_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/slsq_shifter.sv
module slsq_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] word,
    input  logic         shift,
    output logic         msb,
    output logic         last_bit
);

    localparam int BC_W = $clog2(W + 1);

    logic [W-1:0]    sh;
    logic [BC_W-1:0] left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= '0;
            left <= '0;
        end else if (load) begin
            sh   <= word;
            left <= BC_W'(W);
        end else if (shift) begin
            sh <= {sh[W-2:0], 1'b0};
            if (left != '0) begin
                left <= left - 1'b1;
            end
        end
    end

    assign msb      = sh[W-1];
    assign last_bit = (left == BC_W'(1));

endmodule

// File: rtl/serial_load_seq.sv
module serial_load_seq #(
    parameter int NUM_DEV       = 2,
    parameter int DEV_BITS      = 8,
    parameter int SYS_PERIOD_NS = 10,
    parameter int T_SETUP_NS    = 75,
    parameter int T_HOLD_NS     = 75,
    parameter int T_CLKW_NS     = 150,
    parameter int T_DATAW_NS    = 150,
    parameter int T_GAP_NS      = 300,
    parameter int T_STBW_NS     = 100,
    localparam int WORD_W       = NUM_DEV * DEV_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_blank,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              ser_strobe,
    output logic              out_blank
);

    localparam int SETUP_CYC = slsq_pkg::ns_to_cyc(T_SETUP_NS, SYS_PERIOD_NS);
    localparam int HOLD_CYC  = slsq_pkg::ns_to_cyc(T_HOLD_NS,  SYS_PERIOD_NS);
    localparam int CLKH_CYC  = slsq_pkg::ns_to_cyc(T_CLKW_NS,  SYS_PERIOD_NS);
    localparam int DATA_CYC  = slsq_pkg::ns_to_cyc(T_DATAW_NS, SYS_PERIOD_NS);
    localparam int GAP_CYC   = slsq_pkg::ns_to_cyc(T_GAP_NS,   SYS_PERIOD_NS);
    localparam int STB_CYC   = slsq_pkg::ns_to_cyc(T_STBW_NS,  SYS_PERIOD_NS);
    // setup phase also stretches the data window and the clock low time
    localparam int SETUP_LEN = slsq_pkg::max3(SETUP_CYC,
                                              DATA_CYC - CLKH_CYC - HOLD_CYC,
                                              CLKH_CYC - HOLD_CYC);
    localparam int MAX_LEN   = slsq_pkg::max3(slsq_pkg::max3(SETUP_LEN, CLKH_CYC, HOLD_CYC),
                                              GAP_CYC, STB_CYC);
    localparam int CNT_W     = $clog2(MAX_LEN + 1);

    slsq_pkg::seq_state_e state, nxt;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             sh_load;
    logic             sh_shift;
    logic             sh_msb;
    logic             sh_last;
    logic             blank_mode;
    logic             busy_nxt;

    slsq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    slsq_shifter #(.W(WORD_W)) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .word     (in_word),
        .shift    (sh_shift),
        .msb      (sh_msb),
        .last_bit (sh_last)
    );

    assign in_ready = (state == slsq_pkg::ST_IDLE);
    assign ser_data = sh_msb;

    // next state and sequencing strobes
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (state)
            slsq_pkg::ST_IDLE: begin
                if (in_valid) begin
                    nxt      = slsq_pkg::ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(SETUP_LEN - 1);
                    sh_load  = 1'b1;
                end
            end
            slsq_pkg::ST_SETUP: begin
                if (tmr_done) begin
                    nxt      = slsq_pkg::ST_CLK_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(CLKH_CYC - 1);
                end
            end
            slsq_pkg::ST_CLK_HIGH: begin
                if (tmr_done) begin
                    nxt      = slsq_pkg::ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(HOLD_CYC - 1);
                end
            end
            slsq_pkg::ST_HOLD: begin
                if (tmr_done) begin
                    sh_shift = 1'b1;
                    tmr_load = 1'b1;
                    if (sh_last) begin
                        nxt     = slsq_pkg::ST_STROBE_WAIT;
                        tmr_val = CNT_W'(GAP_CYC - 1);
                    end else begin
                        nxt     = slsq_pkg::ST_SETUP;
                        tmr_val = CNT_W'(SETUP_LEN - 1);
                    end
                end
            end
            slsq_pkg::ST_STROBE_WAIT: begin
                if (tmr_done) begin
                    nxt      = slsq_pkg::ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(STB_CYC - 1);
                end
            end
            slsq_pkg::ST_STROBE: begin
                if (tmr_done) begin
                    nxt = slsq_pkg::ST_DONE;
                end
            end
            slsq_pkg::ST_DONE: begin
                nxt = slsq_pkg::ST_IDLE;
            end
            default: begin
                nxt = slsq_pkg::ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= slsq_pkg::ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // blanking request captured with the word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blank_mode <= 1'b0;
        end else if (sh_load) begin
            blank_mode <= in_blank;
        end
    end

    assign busy_nxt = (nxt != slsq_pkg::ST_IDLE) && (nxt != slsq_pkg::ST_DONE);

    // registered pin outputs, decoded from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_clk    <= 1'b0;
            ser_strobe <= 1'b0;
            out_blank  <= 1'b0;
        end else begin
            ser_clk    <= (nxt == slsq_pkg::ST_CLK_HIGH);
            ser_strobe <= (nxt == slsq_pkg::ST_STROBE);
            out_blank  <= busy_nxt && (sh_load ? in_blank : blank_mode);
        end
    end

endmodule

// File: rtl/slsq_checker.sv
module slsq_checker #(
    parameter int CLKH_CYC  = 1,
    parameter int STB_CYC   = 1,
    parameter int SETUP_CYC = 1
) (
    input logic clk,
    input logic rst_n,
    input logic in_ready,
    input logic ser_data,
    input logic ser_clk,
    input logic ser_strobe,
    input logic out_blank
);

    logic [15:0] hi_cnt;
    logic [15:0] stb_cnt;
    logic [15:0] stab_cnt;
    logic        data_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt   <= '0;
            stb_cnt  <= '0;
            stab_cnt <= '0;
            data_d   <= 1'b0;
        end else begin
            hi_cnt  <= ser_clk ? ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1) : 16'd0;
            stb_cnt <= ser_strobe ? ((stb_cnt == 16'hFFFF) ? stb_cnt : stb_cnt + 16'd1) : 16'd0;
            if (ser_data != data_d) begin
                stab_cnt <= 16'd1;
            end else if (stab_cnt != 16'hFFFF) begin
                stab_cnt <= stab_cnt + 16'd1;
            end
            data_d <= ser_data;
        end
    end

    AST_IDLE_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!ser_clk && !ser_strobe && !out_blank)); // R2

    AST_SETUP_BEFORE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> (stab_cnt >= 16'(SETUP_CYC))); // R4

    AST_CLK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_clk) |-> (hi_cnt == 16'(CLKH_CYC))); // R5

    AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data)); // R6

    AST_NO_CLK_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ser_strobe |-> !ser_clk); // R8

    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_strobe) |-> (stb_cnt == 16'(STB_CYC))); // R9

endmodule

bind serial_load_seq slsq_checker #(
    .CLKH_CYC  (CLKH_CYC),
    .STB_CYC   (STB_CYC),
    .SETUP_CYC (SETUP_CYC)
) u_slsq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .ser_data   (ser_data),
    .ser_clk    (ser_clk),
    .ser_strobe (ser_strobe),
    .out_blank  (out_blank)
);

// File: tb/serial_load_seq_bench.sv
module serial_load_seq_bench;

    localparam int W      = 16;
    localparam int PER_NS = 10;

    function automatic int cdiv(input int ns);
        int c;
        c = (ns + PER_NS - 1) / PER_NS;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int SETUP_CYC = cdiv(75);
    localparam int HOLD_CYC  = cdiv(75);
    localparam int CLKH_CYC  = cdiv(150);
    localparam int DATA_CYC  = cdiv(150);
    localparam int GAP_CYC   = cdiv(300);
    localparam int STB_CYC   = cdiv(100);

    function automatic int setup_len();
        int s;
        s = SETUP_CYC;
        if (DATA_CYC - CLKH_CYC - HOLD_CYC > s) s = DATA_CYC - CLKH_CYC - HOLD_CYC;
        if (CLKH_CYC - HOLD_CYC > s) s = CLKH_CYC - HOLD_CYC;
        return s;
    endfunction

    function automatic int busy_cycles();
        return W * (setup_len() + CLKH_CYC + HOLD_CYC) + GAP_CYC + STB_CYC + 1;
    endfunction

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_word = '0;
    logic         in_blank = 1'b0;
    logic         ser_data, ser_clk, ser_strobe, out_blank;

    always #5 clk = ~clk;

    serial_load_seq u_serial_load_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_word    (in_word),
        .in_blank   (in_blank),
        .ser_data   (ser_data),
        .ser_clk    (ser_clk),
        .ser_strobe (ser_strobe),
        .out_blank  (out_blank)
    );

    // behavioural driver chain: shift on clock rise, transparent latch while strobe high
    logic [W-1:0] chain = '0;
    logic [W-1:0] latch = '0;
    always @(posedge ser_clk) chain <= {chain[W-2:0], ser_data};
    always @* if (ser_strobe) latch = chain;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 0;
    bit  exp_blank = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // interval monitor, sampling at falling edges
    bit p_clk = 0, p_data = 0, p_stb = 0;
    int run = 1000, hi_run = 0, stb_run = 0, since_fall = 1000, since_rise = 1000, rises = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ser_clk && !p_clk) begin
                chk(ser_data == p_data && run >= SETUP_CYC, "R4 data setup before clock rise", run, SETUP_CYC);
                chk(out_blank == exp_blank, "R10 blanking while shifting", out_blank, exp_blank);
                rises++;
                since_rise = 0;
            end
            if (!ser_clk && p_clk) begin
                chk(hi_run == CLKH_CYC, "R5 clock high width", hi_run, CLKH_CYC);
                since_fall = 0;
            end
            if (ser_data != p_data) begin
                chk(!ser_clk && !p_clk && since_fall >= HOLD_CYC, "R6 data hold after clock", since_fall, HOLD_CYC);
                chk(run >= DATA_CYC, "R7 data valid width", run, DATA_CYC);
            end
            if (ser_strobe && !p_stb) begin
                chk(since_rise >= GAP_CYC && !ser_clk, "R8 clock to strobe gap", since_rise, GAP_CYC);
                chk(rises == W, "R9 R3 clock pulses before strobe", rises, W);
                rises = 0;
            end
            if (!ser_strobe && p_stb) begin
                chk(stb_run == STB_CYC, "R9 strobe width", stb_run, STB_CYC);
                chk(out_blank == 1'b0, "R10 blanking released after strobe", out_blank, 0);
            end
            run        = (ser_data == p_data) ? run + 1 : 1;
            hi_run     = ser_clk ? hi_run + 1 : 0;
            stb_run    = ser_strobe ? stb_run + 1 : 0;
            since_fall = since_fall + 1;
            since_rise = since_rise + 1;
            p_clk  = ser_clk;
            p_data = ser_data;
            p_stb  = ser_strobe;
        end
    end

    task automatic do_load(input logic [W-1:0] w, input bit blk);
        int n;
        @(negedge clk);
        in_valid  = 1'b1;
        in_word   = w;
        in_blank  = blk;
        exp_blank = blk;
        @(posedge clk);
        @(negedge clk);
        chk(in_ready == 1'b0, "R2 ready drops after acceptance", in_ready, 0);
        // keep offering a different request while busy: must be ignored
        in_word  = ~w;
        in_blank = ~blk;
        n = 0;
        while (!in_ready) begin
            n++;
            if (n == 3) in_valid = 1'b0;
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk(n == busy_cycles(), "R2 R12 busy length in cycles", n, busy_cycles());
        chk(latch == w, "R3 latched chain equals word", latch, w);
        chk(latch == w, "R11 mid-load request ignored", latch, w);
        chk((latch & ~{W{out_blank}}) == w, "R10 driver outputs enabled after load", latch & ~{W{out_blank}}, w);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1, "R1 ready in reset", in_ready, 1);
        chk({ser_data, ser_clk, ser_strobe, out_blank} == 4'b0, "R1 pins low in reset",
            {ser_data, ser_clk, ser_strobe, out_blank}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
        chk({ser_data, ser_clk, ser_strobe, out_blank} == 4'b0, "R1 pins low after reset",
            {ser_data, ser_clk, ser_strobe, out_blank}, 0);
        chk(SETUP_CYC == 8 && HOLD_CYC == 8 && CLKH_CYC == 15 && GAP_CYC == 30 && STB_CYC == 10,
            "R12 default cycle conversion", SETUP_CYC, 8);

        do_load(16'h0000, 1'b0);
        do_load(16'hFFFF, 1'b1);
        do_load(16'h5555, 1'b0);
        do_load(16'h8000, 1'b1);
        do_load(16'h0001, 1'b0);
        for (int i = 0; i < 10; i++) begin
            do_load(W'($urandom), 1'($urandom));
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule